// File: doc/BRIEF.md
# Programmable Interval Timer with Compare, Capture and PWM Channels

This block is a counter timer with a clock divider, a period register and a small set of channels that share one counter. The counter either climbs from zero to the period value and restarts, or sweeps up to the period value and back down to zero for symmetric waveforms. Each channel compares the shared count with its own threshold to form a pulse-width waveform or a toggling output. A channel can also latch the running count when its input pin changes.

Software writes the divider, period and thresholds through a narrow write port into holding copies. The working copies pick those values up only when a period completes, so frequency and duty change cleanly at a period boundary and never mid-cycle. One-cycle pulses report the top and bottom turning points. Per-channel sticky flags report matches, captures and captures that were missed.

Top module: `cmp_timer`

## Requirements
- R1: Write addresses: 0 control (bit 0 run enable, bit 1 center sweep), 1 divider, 2 period, 3 flag clear (bit k clears channel k flag and miss bit), 4+2k channel k mode (bits 1:0: 0 pulse-width, 1 toggle, 2 capture, 3 off; bit 2 capture edge, 0 rising, 1 falling), 5+2k channel k threshold.
- R2: While run enable is 0 the count and divider stay at 0 and the working copies follow the holding copies, so values written before enabling apply from the first count.
- R3: In ramp mode, with divider value P, the count steps once every P+1 clocks from 0 to the period value and then restarts at 0. A one-cycle top pulse appears in the cycle the count shows 0 after the wrap.
- R4: In center mode the count rises to the period value, with the top pulse in the cycle it shows the period value. It then falls to 0, with the bottom pulse in the cycle it shows 0. One sweep lasts 2×period steps.
- R5: Divider, period and threshold writes made while running take effect only at the end of the current period (ramp: wrap; center: bottom).
- R6: A pulse-width channel is high while the count is below its threshold. Threshold 0 gives a constant low and a threshold above the period value gives a constant high.
- R7: A channel in pulse-width or toggle mode sets its flag one cycle after the count steps onto a value equal to its threshold; unequal values never set it.
- R8: In toggle mode the output inverts at every match, so it changes level once per period.
- R9: In capture mode the selected edge of the channel input, passed through two synchronizer stages, copies the count into the channel threshold and sets the flag. Period ends never overwrite a captured value.
- R10: A capture while the flag is already set sets the miss bit. A clear write resets both, and a new event in the same cycle wins over the clear.
- R11: Top and bottom pulses never occur together, and a miss bit is never set without its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | CW | Register write data |
| cap_in | input | NCH | Channel capture inputs |
| ch_out | output | NCH | Channel waveforms |
| ovf_evt | output | 1 | Top turning-point pulse |
| unf_evt | output | 1 | Bottom turning-point pulse |
| ch_flag | output | NCH | Sticky match/capture flags |
| ch_ovcap | output | NCH | Sticky missed-capture bits |
| cnt_val | output | CW | Current count |
| cmp_val | output | NCH*CW | Working thresholds, channel k at bits k*CW upward |

## Verification
The waveform generator runs under several combinations of ramp and center sweep, divider value and threshold. The thresholds include zero, a mid value and one past the period. Period length and high time are measured between turning pulses, which separates divider errors from period errors and sweep-shape errors. The boundary thresholds show whether the constant-low and constant-high cases hold. A write made early in a period must leave that period's length intact. A toggle channel with an out-of-range threshold shows whether the compare tests only equality. Capture runs on rising and falling inputs and with a flag already pending, and they check the latched count against the count seen when the flag rises.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  typedef enum logic [1:0] {
    CH_PWM = 2'd0,
    CH_TGL = 2'd1,
    CH_CAP = 2'd2,
    CH_OFF = 2'd3
  } ch_mode_e;

  localparam int unsigned ADR_CTRL    = 0;
  localparam int unsigned ADR_DIV     = 1;
  localparam int unsigned ADR_PERIOD  = 2;
  localparam int unsigned ADR_CLEAR   = 3;
  localparam int unsigned ADR_CH_BASE = 4;
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [CW-1:0]            wr_data,
  input  logic                     load_i,
  input  logic [NCH-1:0]           cap_we_i,
  input  logic [CW-1:0]            cap_val_i,
  output logic                     en_o,
  output logic                     center_o,
  output logic [NCH-1:0]           clr_o,
  output logic [CW-1:0]            div_o,
  output logic [CW-1:0]            per_o,
  output logic [NCH-1:0][CW-1:0]   thr_o,
  output logic [NCH-1:0][1:0]      mode_o,
  output logic [NCH-1:0]           esel_o
);
  logic          en_q, en_d, ctr_q, ctr_d;
  logic [CW-1:0] div_pre_q, div_pre_d, per_pre_q, per_pre_d;
  logic [CW-1:0] div_act_q, div_act_d, per_act_q, per_act_d;
  logic          wr_ctrl, wr_div, wr_per, wr_clr;

  assign wr_ctrl = wr_en && (wr_addr == AW'(ADR_CTRL));
  assign wr_div  = wr_en && (wr_addr == AW'(ADR_DIV));
  assign wr_per  = wr_en && (wr_addr == AW'(ADR_PERIOD));
  assign wr_clr  = wr_en && (wr_addr == AW'(ADR_CLEAR));

  always_comb begin
    en_d      = en_q;
    ctr_d     = ctr_q;
    div_pre_d = div_pre_q;
    per_pre_d = per_pre_q;
    div_act_d = div_act_q;
    per_act_d = per_act_q;
    if (wr_ctrl) begin
      en_d  = wr_data[0];
      ctr_d = wr_data[1];
    end
    if (wr_div) div_pre_d = wr_data;
    if (wr_per) per_pre_d = wr_data;
    if (load_i) begin
      div_act_d = div_pre_q;
      per_act_d = per_pre_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      ctr_q     <= 1'b0;
      div_pre_q <= '0;
      per_pre_q <= '0;
      div_act_q <= '0;
      per_act_q <= '0;
    end else begin
      en_q      <= en_d;
      ctr_q     <= ctr_d;
      div_pre_q <= div_pre_d;
      per_pre_q <= per_pre_d;
      div_act_q <= div_act_d;
      per_act_q <= per_act_d;
    end
  end

  assign en_o     = en_q;
  assign center_o = ctr_q;
  assign div_o    = div_act_q;
  assign per_o    = per_act_q;
  assign clr_o    = wr_clr ? wr_data[NCH-1:0] : '0;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam int unsigned MODE_ADR = ADR_CH_BASE + 2 * k;
    localparam int unsigned THR_ADR  = ADR_CH_BASE + 2 * k + 1;
    logic [1:0]    mode_q, mode_d;
    logic          esel_q, esel_d;
    logic [CW-1:0] pre_q, pre_d, act_q, act_d;

    always_comb begin
      mode_d = mode_q;
      esel_d = esel_q;
      pre_d  = pre_q;
      act_d  = act_q;
      if (wr_en && (wr_addr == AW'(MODE_ADR))) begin
        mode_d = wr_data[1:0];
        esel_d = wr_data[2];
      end
      if (wr_en && (wr_addr == AW'(THR_ADR))) pre_d = wr_data;
      if (cap_we_i[k]) begin
        act_d = cap_val_i;
      end else if (load_i && (mode_q != 2'(CH_CAP))) begin
        act_d = pre_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q <= 2'(CH_PWM);
        esel_q <= 1'b0;
        pre_q  <= '0;
        act_q  <= '0;
      end else begin
        mode_q <= mode_d;
        esel_q <= esel_d;
        pre_q  <= pre_d;
        act_q  <= act_d;
      end
    end

    assign mode_o[k] = mode_q;
    assign esel_o[k] = esel_q;
    assign thr_o[k]  = act_q;
  end
endmodule

// File: rtl/cmp_timer_base.sv
module cmp_timer_base #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          center_i,
  input  logic [CW-1:0] div_i,
  input  logic [CW-1:0] per_i,
  output logic [CW-1:0] cnt_o,
  output logic          step_o,
  output logic          upd_o,
  output logic          top_o,
  output logic          bot_o
);
  logic [CW-1:0] div_q, div_d, cnt_q, cnt_d;
  logic          down_q, down_d;
  logic          top_q, top_d, bot_q, bot_d, step_q, step_d;
  logic          tick;

  assign tick = en_i && (div_q == div_i);

  always_comb begin
    div_d  = div_q;
    cnt_d  = cnt_q;
    down_d = down_q;
    top_d  = 1'b0;
    bot_d  = 1'b0;
    upd_o  = 1'b0;
    step_d = tick;
    if (!en_i) begin
      div_d  = '0;
      cnt_d  = '0;
      down_d = 1'b0;
    end else begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (!center_i) begin
          down_d = 1'b0;
          if (cnt_q == per_i) begin
            cnt_d = '0;
            top_d = 1'b1;
            upd_o = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (!down_q) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == per_i - 1'b1) begin
            top_d  = 1'b1;
            down_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == {{(CW-1){1'b0}}, 1'b1}) begin
            bot_d  = 1'b1;
            down_d = 1'b0;
            upd_o  = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt_q  <= '0;
      down_q <= 1'b0;
      top_q  <= 1'b0;
      bot_q  <= 1'b0;
      step_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      down_q <= down_d;
      top_q  <= top_d;
      bot_q  <= bot_d;
      step_q <= step_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign step_o = step_q;
  assign top_o  = top_q;
  assign bot_o  = bot_q;
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import cmp_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          esel_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          step_i,
  input  logic [CW-1:0] thr_i,
  input  logic          pin_i,
  input  logic          clr_i,
  output logic          out_o,
  output logic          flag_o,
  output logic          miss_o,
  output logic          cap_we_o
);
  logic s1_q, s2_q, s3_q;
  logic tgl_q, tgl_d, flag_q, flag_d, miss_q, miss_d;
  logic is_cmp, match, cap_evt;
  ch_mode_e mode;

  assign mode    = ch_mode_e'(mode_i);
  assign is_cmp  = (mode == CH_PWM) || (mode == CH_TGL);
  assign match   = is_cmp && step_i && (cnt_i == thr_i);
  assign cap_evt = (mode == CH_CAP) && (esel_i ? (s3_q && !s2_q) : (s2_q && !s3_q));

  always_comb begin
    tgl_d  = tgl_q;
    flag_d = flag_q;
    miss_d = miss_q;
    if (clr_i) begin
      flag_d = 1'b0;
      miss_d = 1'b0;
    end
    if (match && (mode == CH_TGL)) tgl_d = !tgl_q;
    if (match || cap_evt) flag_d = 1'b1;
    if (cap_evt && flag_q) miss_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      tgl_q  <= 1'b0;
      flag_q <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      tgl_q  <= tgl_d;
      flag_q <= flag_d;
      miss_q <= miss_d;
    end
  end

  always_comb begin
    unique case (mode)
      CH_PWM:  out_o = (cnt_i < thr_i);
      CH_TGL:  out_o = tgl_q;
      default: out_o = 1'b0;
    endcase
  end

  assign flag_o   = flag_q;
  assign miss_o   = miss_q;
  assign cap_we_o = cap_evt;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CW  = 16,
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic [NCH-1:0]    cap_in,
  output logic [NCH-1:0]    ch_out,
  output logic              ovf_evt,
  output logic              unf_evt,
  output logic [NCH-1:0]    ch_flag,
  output logic [NCH-1:0]    ch_ovcap,
  output logic [NCH*CW-1:0] cmp_val,
  output logic [CW-1:0]     cnt_val
);
  logic rs1_q, rs2_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_core_n = rs2_q;

  logic                   run_en, center, upd, step, load;
  logic [CW-1:0]          div_act, per_act, cnt;
  logic [NCH-1:0]         clr, cap_we, esel;
  logic [NCH-1:0][CW-1:0] thr;
  logic [NCH-1:0][1:0]    mode;

  assign load = !run_en || upd;

  cmp_timer_regs #(.CW(CW), .NCH(NCH), .AW(AW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .load_i    (load),
    .cap_we_i  (cap_we),
    .cap_val_i (cnt),
    .en_o      (run_en),
    .center_o  (center),
    .clr_o     (clr),
    .div_o     (div_act),
    .per_o     (per_act),
    .thr_o     (thr),
    .mode_o    (mode),
    .esel_o    (esel)
  );

  cmp_timer_base #(.CW(CW)) base_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .en_i     (run_en),
    .center_i (center),
    .div_i    (div_act),
    .per_i    (per_act),
    .cnt_o    (cnt),
    .step_o   (step),
    .upd_o    (upd),
    .top_o    (ovf_evt),
    .bot_o    (unf_evt)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    cmp_timer_chan #(.CW(CW)) chan_i (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .mode_i   (mode[k]),
      .esel_i   (esel[k]),
      .cnt_i    (cnt),
      .step_i   (step),
      .thr_i    (thr[k]),
      .pin_i    (cap_in[k]),
      .clr_i    (clr[k]),
      .out_o    (ch_out[k]),
      .flag_o   (ch_flag[k]),
      .miss_o   (ch_ovcap[k]),
      .cap_we_o (cap_we[k])
    );
    assign cmp_val[k*CW +: CW] = thr[k];
  end

  assign cnt_val = cnt;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CW  = 16,
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run_en,
  input logic           center,
  input logic           upd,
  input logic [CW-1:0]  per_act,
  input logic [CW-1:0]  cnt_val,
  input logic           ovf_evt,
  input logic           unf_evt,
  input logic [NCH-1:0] ch_flag,
  input logic [NCH-1:0] ch_ovcap
);
  a_r11_turns_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_evt && unf_evt));

  a_r11_miss_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ovcap & ~ch_flag) == '0);

  a_r2_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> cnt_val == '0);

  a_r3_ramp_wraps_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !$past(center)) |-> cnt_val == '0);

  a_r4_center_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && $past(center)) |-> cnt_val == $past(per_act));

  a_r4_bottom_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |-> cnt_val == '0);

  a_r5_period_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_en) && !$past(upd)) |-> per_act == $past(per_act));
endmodule

bind cmp_timer cmp_timer_chk #(.CW(CW), .NCH(NCH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .run_en   (run_en),
  .center   (center),
  .upd      (upd),
  .per_act  (per_act),
  .cnt_val  (cnt_val),
  .ovf_evt  (ovf_evt),
  .unf_evt  (unf_evt),
  .ch_flag  (ch_flag),
  .ch_ovcap (ch_ovcap)
);

// File: tb/cmp_timer_tb_top.sv
module cmp_timer_tb_top;
  localparam int CW  = 16;
  localparam int NCH = 2;
  localparam int AW  = 4;
  localparam int NV  = 7;

  // {center, period, threshold, divider, expected period clocks, expected high clocks}
  localparam logic [95:0] VEC [NV] = '{
    {16'd0, 16'd9, 16'd3,  16'd0, 16'd10, 16'd3},
    {16'd0, 16'd9, 16'd0,  16'd1, 16'd20, 16'd0},
    {16'd0, 16'd9, 16'd12, 16'd0, 16'd10, 16'd10},
    {16'd0, 16'd4, 16'd2,  16'd2, 16'd15, 16'd6},
    {16'd1, 16'd5, 16'd2,  16'd0, 16'd10, 16'd3},
    {16'd1, 16'd6, 16'd7,  16'd1, 16'd24, 16'd24},
    {16'd1, 16'd8, 16'd4,  16'd0, 16'd16, 16'd7}
  };

  logic              clk, rst_n, wr_en;
  logic [AW-1:0]     wr_addr;
  logic [CW-1:0]     wr_data;
  logic [NCH-1:0]    cap_in, ch_out, ch_flag, ch_ovcap;
  logic              ovf_evt, unf_evt;
  logic [NCH*CW-1:0] cmp_val;
  logic [CW-1:0]     cnt_val;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cmp_timer #(.CW(CW), .NCH(NCH), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_in(cap_in), .ch_out(ch_out), .ovf_evt(ovf_evt), .unf_evt(unf_evt),
    .ch_flag(ch_flag), .ch_ovcap(ch_ovcap), .cmp_val(cmp_val), .cnt_val(cnt_val)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = AW'(a);
    wr_data = CW'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_ev(input bit bottom);
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!(bottom ? unf_evt : ovf_evt) && g < 5000);
  endtask

  task automatic measure(input bit ctr, input int per_v, output int per, output int hi);
    wait_ev(ctr);
    chk(cnt_val == 0, ctr ? "R4 bottom count" : "R3 wrap count", int'(cnt_val), 0);
    hi  = int'(ch_out[0]);
    per = 1;
    while (1) begin
      @(negedge clk);
      if ((ctr ? unf_evt : ovf_evt) || per > 5000) break;
      if (ctr && ovf_evt) chk(cnt_val == CW'(per_v), "R4 peak count", int'(cnt_val), per_v);
      hi += int'(ch_out[0]);
      per++;
    end
  endtask

  function automatic int thr1();
    return int'(cmp_val[CW +: CW]);
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int per, hi, c, n;
    logic o1, o2, o3;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    cap_in  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(cnt_val == 0, "R2 reset count", int'(cnt_val), 0);
    chk(ch_out == 0 && ch_flag == 0 && ch_ovcap == 0, "R6 reset outputs",
        int'({ch_out, ch_flag, ch_ovcap}), 0);
    chk(!ovf_evt && !unf_evt, "R11 reset pulses", int'({ovf_evt, unf_evt}), 0);

    // R2: configured but disabled, the count stays at zero
    wr(2, 5);
    wr(1, 0);
    repeat (20) @(negedge clk);
    chk(cnt_val == 0, "R2 idle hold", int'(cnt_val), 0);

    // table walk: R1 R3 R4 R6
    for (int i = 0; i < NV; i++) begin
      logic [95:0] v;
      v = VEC[i];
      wr(0, 0);
      wr(1, int'(v[47:32]));
      wr(2, int'(v[79:64]));
      wr(4, 0);
      wr(5, int'(v[63:48]));
      wr(3, 3);
      wr(0, {v[80], 1'b1});
      measure(v[80], int'(v[79:64]), per, hi);
      chk(per == int'(v[31:16]), "R3 R4 period length", per, int'(v[31:16]));
      chk(hi == int'(v[15:0]), "R6 high time", hi, int'(v[15:0]));
      if (i == 0) chk(ch_flag[0] == 1'b1, "R7 pulse-width flag", int'(ch_flag[0]), 1);
    end

    // R2: disabling returns the count to zero and holds it
    wr(0, 0);
    @(negedge clk);
    chk(cnt_val == 0, "R2 disable clears", int'(cnt_val), 0);
    repeat (10) @(negedge clk);
    chk(cnt_val == 0, "R2 disable holds", int'(cnt_val), 0);

    // R5: writes while running wait for the period end
    wr(1, 0);
    wr(2, 9);
    wr(5, 3);
    wr(0, 1);
    wait_ev(1'b0);
    n = 0;
    wr(2, 19);
    wr(5, 6);
    n = 4;
    while (n < 100) begin
      @(negedge clk);
      n++;
      if (ovf_evt) break;
    end
    chk(n == 10, "R5 current period kept", n, 10);
    measure(1'b0, 19, per, hi);
    chk(per == 20, "R5 new period", per, 20);
    chk(hi == 6, "R5 new duty", hi, 6);

    // R8 / R7: toggle channel 1
    wr(0, 0);
    wr(2, 9);
    wr(6, 1);
    wr(7, 4);
    wr(3, 3);
    wr(0, 1);
    wait_ev(1'b0);
    o1 = ch_out[1];
    wait_ev(1'b0);
    o2 = ch_out[1];
    wait_ev(1'b0);
    o3 = ch_out[1];
    chk(o2 != o1, "R8 toggle once", int'(o2), int'(!o1));
    chk(o3 != o2, "R8 toggle again", int'(o3), int'(!o2));
    chk(ch_flag[1] == 1'b1, "R7 toggle flag set", int'(ch_flag[1]), 1);
    wr(3, 2);
    chk(ch_flag[1] == 1'b0, "R10 clear flag", int'(ch_flag[1]), 0);
    wr(7, 15);
    wait_ev(1'b0);
    wr(3, 2);
    o1 = ch_out[1];
    wait_ev(1'b0);
    wait_ev(1'b0);
    chk(ch_flag[1] == 1'b0, "R7 no match above period", int'(ch_flag[1]), 0);
    chk(ch_out[1] == o1, "R7 no toggle above period", int'(ch_out[1]), int'(o1));

    // R9 / R10: capture on channel 1
    wr(0, 0);
    wr(2, 1000);
    wr(6, 2);
    wr(3, 3);
    wr(0, 1);
    repeat (20) @(negedge clk);
    cap_in[1] = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ch_flag[1] && n < 20);
    c = int'(cnt_val);
    chk(n == 3, "R9 sync latency", n, 3);
    chk(thr1() == c - 1, "R9 rising capture value", thr1(), c - 1);
    chk(ch_ovcap[1] == 1'b0, "R10 no miss on first", int'(ch_ovcap[1]), 0);
    wr(7, 77);
    wait_ev(1'b0);
    @(negedge clk);
    chk(thr1() == c - 1, "R9 capture kept at period end", thr1(), c - 1);
    cap_in[1] = 1'b0;
    repeat (5) @(negedge clk);
    chk(ch_ovcap[1] == 1'b0, "R9 falling ignored in rising mode", int'(ch_ovcap[1]), 0);
    cap_in[1] = 1'b1;
    repeat (5) @(negedge clk);
    chk(ch_ovcap[1] == 1'b1 && ch_flag[1] == 1'b1, "R10 miss on pending flag",
        int'({ch_ovcap[1], ch_flag[1]}), 3);
    wr(3, 2);
    chk(ch_ovcap[1] == 1'b0 && ch_flag[1] == 1'b0, "R10 clear both",
        int'({ch_ovcap[1], ch_flag[1]}), 0);
    wr(6, 6);
    cap_in[1] = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ch_flag[1] && n < 20);
    c = int'(cnt_val);
    chk(thr1() == c - 1, "R9 falling capture value", thr1(), c - 1);
    chk(ch_ovcap[1] == 1'b0, "R10 no miss after clear", int'(ch_ovcap[1]), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule